// File: doc/BRIEF.md
# Fusible Instruction Pair Detector

This block sits in a RISC-V decode stage and inspects two adjacent 32-bit instruction words: the older one and the younger one that follows it. It decides whether the pair forms one of nine supported idioms that a back end may execute as a single operation. These idioms are address generation followed by a load, or a left shift followed by a logical right shift. When a pair qualifies, the block raises a fuse flag, reports the idiom as a one-hot kind code and gives the register that both instructions write.

Every idiom has a chain condition. The younger instruction must take the older one's destination as its base (or shift source), and it must write that same register. The pair is turned down when that register is x0, when either word is marked invalid, or when the idiom's bit in the enable mask is clear. Results are registered, so they appear one clock after the words are presented.

Top module: `fuse_pair_detect`

## Requirements
- R1: An ADD (opcode 0110011, funct3 000, funct7 0000000) followed by an LW (opcode 0000011, funct3 010) fuses as kind bit 0, but only when the LW immediate (bits 31:20) is zero.
- R2: An AUIPC (opcode 0010111) followed by an LD (opcode 0000011, funct3 011) fuses as kind bit 1. A LUI (opcode 0110111) followed by an LD fuses as kind bit 2. Both fuse for any load offset.
- R3: An SLLI (opcode 0010011, funct3 001, bits 31:26 zero) followed by an SRLI (opcode 0010011, funct3 101, bits 31:26 zero) fuses as kind bit 3 for any pair of shift amounts. An arithmetic right shift (bits 31:26 = 010000) does not fuse.
- R4: An ADDI (opcode 0010011, funct3 000) fuses as kind bit 4 when followed by an LD, and as kind bit 5 when followed by an LW, with any load offset.
- R5: An ADD.UW (opcode 0111011, funct3 000, funct7 0000100) followed by an LW fuses as kind bit 6. The same instruction followed by any other load does not fuse.
- R6: An SH1ADD, SH2ADD or SH3ADD (opcode 0110011, funct7 0010000, funct3 010/100/110) followed by an LB, LH, LW or LD (load funct3 000/001/010/011) fuses as kind bit 7. The same shift-adds with opcode 0111011 fuse with those loads as kind bit 8. Unsigned loads (funct3 100 or above) do not fuse.
- R7: A pair fuses only when the younger rs1 (bits 19:15) and the younger rd (bits 11:7) both equal the older rd. A pair whose order is swapped does not fuse.
- R8: A pair whose shared destination is x0 never fuses.
- R9: A pair never fuses when either valid input is low.
- R10: A kind whose bit is clear in the enable mask never fuses. The other kinds are unaffected.
- R11: The kind code has at most one bit set. The fuse flag is high exactly when one bit is set. When the flag is low, the kind code and the destination are both zero. When the flag is high, the destination is the shared rd.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high reset holds all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| old_valid | input | 1 | Older instruction word is valid |
| old_insn | input | 32 | Older instruction word |
| young_valid | input | 1 | Younger instruction word is valid |
| young_insn | input | 32 | Younger instruction word |
| pat_en | input | 9 | Per-kind enable mask, bit i enables kind i |
| fuse_q | output | 1 | Registered fuse flag |
| kind_q | output | 9 | Registered one-hot kind code |
| dest_q | output | 5 | Registered shared destination register |

## Verification
The block has no parameters, so the bench builds it at its fixed nine-kind width with all 32 encodings and the full enable mask within reach. With the full mask, each kind is driven through its accepted forms: every shift-add with every width of signed load, extreme shift amounts, and negative and maximum offsets. Near misses are also driven: a nonzero offset after ADD, an arithmetic right shift, unsigned loads, broken register chains, x0, and invalid words. With a partial mask, the bench shows that one kind can be switched off while another still fuses. Pairs are issued back to back so that every cycle's result is checked against the inputs of the cycle before.

// File: rtl/fuse_pair_detect.sv
`timescale 1ns/1ps
module fuse_pair_detect (
  input  logic        clk,
  input  logic        rst,
  input  logic        old_valid,
  input  logic [31:0] old_insn,
  input  logic        young_valid,
  input  logic [31:0] young_insn,
  input  logic [8:0]  pat_en,
  output logic        fuse_q,
  output logic [8:0]  kind_q,
  output logic [4:0]  dest_q
);
  localparam int NK = 9;

  wire [6:0] o_op = old_insn[6:0];
  wire [2:0] o_f3 = old_insn[14:12];
  wire [6:0] o_f7 = old_insn[31:25];
  wire [4:0] o_rd = old_insn[11:7];
  wire [6:0] y_op = young_insn[6:0];
  wire [2:0] y_f3 = young_insn[14:12];
  wire [4:0] y_rd = young_insn[11:7];
  wire [4:0] y_rs1 = young_insn[19:15];

  wire sh_f3    = (o_f3 == 3'b010) || (o_f3 == 3'b100) || (o_f3 == 3'b110);
  wire o_add    = o_op == 7'h33 && o_f3 == 3'b000 && o_f7 == 7'h00;
  wire o_adduw  = o_op == 7'h3b && o_f3 == 3'b000 && o_f7 == 7'h04;
  wire o_shadd  = o_op == 7'h33 && o_f7 == 7'h10 && sh_f3;
  wire o_shuw   = o_op == 7'h3b && o_f7 == 7'h10 && sh_f3;
  wire o_auipc  = o_op == 7'h17;
  wire o_lui    = o_op == 7'h37;
  wire o_addi   = o_op == 7'h13 && o_f3 == 3'b000;
  wire o_slli   = o_op == 7'h13 && o_f3 == 3'b001 && old_insn[31:26] == 6'd0;

  wire y_load   = y_op == 7'h03;
  wire y_lw     = y_load && y_f3 == 3'b010;
  wire y_ld     = y_load && y_f3 == 3'b011;
  wire y_signld = y_load && !y_f3[2];
  wire y_srli   = y_op == 7'h13 && y_f3 == 3'b101 && young_insn[31:26] == 6'd0;
  wire y_zoff   = young_insn[31:20] == 12'd0;

  wire chain = old_valid && young_valid && o_rd != 5'd0 &&
               y_rd == o_rd && y_rs1 == o_rd;

  logic [NK-1:0] hit, pick;
  assign hit = {NK{chain}} & pat_en & {
    o_shuw  && y_signld,
    o_shadd && y_signld,
    o_adduw && y_lw,
    o_addi  && y_lw,
    o_addi  && y_ld,
    o_slli  && y_srli,
    o_lui   && y_ld,
    o_auipc && y_ld,
    o_add   && y_lw && y_zoff
  };
  assign pick = hit & (~hit + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse_q <= 1'b0;
      kind_q <= '0;
      dest_q <= '0;
    end else begin
      fuse_q <= |pick;
      kind_q <= pick;
      dest_q <= (|pick) ? o_rd : 5'd0;
    end
  end
endmodule

module fuse_pair_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       old_valid,
  input logic       young_valid,
  input logic [8:0] pat_en,
  input logic       fuse_q,
  input logic [8:0] kind_q,
  input logic [4:0] dest_q
);
  assert_kind_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(kind_q));
  assert_flag_matches_kind_R11: assert property (@(posedge clk) disable iff (rst)
    fuse_q == ($countones(kind_q) == 1));
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !fuse_q |-> (dest_q == 5'd0 && kind_q == 9'd0));
  assert_no_x0_R8: assert property (@(posedge clk) disable iff (rst)
    fuse_q |-> dest_q != 5'd0);
  assert_valid_needed_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!fuse_q || ($past(old_valid) && $past(young_valid))));
  assert_enable_gates_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((kind_q & ~$past(pat_en)) == 9'd0));
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!fuse_q && kind_q == 9'd0 && dest_q == 5'd0));
endmodule

bind fuse_pair_detect fuse_pair_detect_chk u_chk (
  .clk(clk), .rst(rst), .old_valid(old_valid), .young_valid(young_valid),
  .pat_en(pat_en), .fuse_q(fuse_q), .kind_q(kind_q), .dest_q(dest_q)
);

// File: tb/fuse_pair_detect_test.sv
`timescale 1ns/1ps
module fuse_pair_detect_test;
  logic clk = 1'b0, rst = 1'b1;
  logic old_valid = 1'b0, young_valid = 1'b0;
  logic [31:0] old_insn = '0, young_insn = '0;
  logic [8:0] pat_en = '1;
  logic fuse_q;
  logic [8:0] kind_q;
  logic [4:0] dest_q;

  always #2.5 clk = ~clk;

  fuse_pair_detect uut (
    .clk(clk), .rst(rst), .old_valid(old_valid), .old_insn(old_insn),
    .young_valid(young_valid), .young_insn(young_insn), .pat_en(pat_en),
    .fuse_q(fuse_q), .kind_q(kind_q), .dest_q(dest_q)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [8:0] q_kind[$];
  logic [4:0] q_dest[$];
  string      q_tag[$];

  function automatic logic [31:0] ity(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] rty(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] uty(input logic [19:0] imm, input logic [4:0] rd,
                                      input logic [6:0] op);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] ldi(input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [4:0] rs1, input logic [11:0] imm);
    return ity(imm, rs1, f3, rd, 7'h03);
  endfunction

  task automatic drive(input logic r, input logic ov, input logic [31:0] o,
                       input logic yv, input logic [31:0] y, input logic [8:0] en,
                       input logic [8:0] ek, input logic [4:0] ed, input string tag);
    @(negedge clk);
    rst = r; old_valid = ov; old_insn = o; young_valid = yv; young_insn = y; pat_en = en;
    q_kind.push_back(ek);
    q_dest.push_back(ek != 0 ? ed : 5'd0);
    q_tag.push_back(tag);
  endtask

  task automatic pair(input logic [31:0] o, input logic [31:0] y,
                      input logic [8:0] ek, input logic [4:0] ed, input string tag);
    drive(1'b0, 1'b1, o, 1'b1, y, 9'h1ff, ek, ed, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_kind.size() > 0) begin
      logic [8:0] ek;
      logic [4:0] ed;
      string t;
      ek = q_kind.pop_front();
      ed = q_dest.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (kind_q !== ek || dest_q !== ed || fuse_q !== (ek != 0)) begin
        fails++;
        $display("FAIL %s: got fuse=%0b kind=%b dest=%0d, expected fuse=%0b kind=%b dest=%0d",
                 t, fuse_q, kind_q, dest_q, (ek != 0), ek, ed);
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] add5, lw5;
    add5 = rty(7'h00, 5'd7, 5'd6, 3'b000, 5'd5, 7'h33);
    lw5  = ldi(3'b010, 5'd5, 5'd5, 12'd0);
    // R12: reset holds outputs at zero even with a fusible pair present
    drive(1'b1, 1'b1, add5, 1'b1, lw5, 9'h1ff, 9'd0, 5'd0, "R12 reset");
    drive(1'b1, 1'b1, add5, 1'b1, lw5, 9'h1ff, 9'd0, 5'd0, "R12 reset");
    // R1
    pair(add5, lw5, 9'h001, 5'd5, "R1 add+lw off0");
    pair(add5, ldi(3'b010, 5'd5, 5'd5, 12'd4), 9'h000, 5'd0, "R1 add+lw off4");
    // R2
    pair(uty(20'h12345, 5'd10, 7'h17), ldi(3'b011, 5'd10, 5'd10, 12'hff8), 9'h002, 5'd10, "R2 auipc+ld");
    pair(uty(20'hfffff, 5'd11, 7'h37), ldi(3'b011, 5'd11, 5'd11, 12'h7ff), 9'h004, 5'd11, "R2 lui+ld");
    pair(uty(20'h1, 5'd11, 7'h37), ldi(3'b010, 5'd11, 5'd11, 12'h0), 9'h000, 5'd0, "R2 lui+lw");
    // R3
    pair(ity(12'd40, 5'd13, 3'b001, 5'd12, 7'h13), ity(12'd63, 5'd12, 3'b101, 5'd12, 7'h13), 9'h008, 5'd12, "R3 slli+srli");
    pair(ity(12'd0, 5'd13, 3'b001, 5'd12, 7'h13), ity(12'd0, 5'd12, 3'b101, 5'd12, 7'h13), 9'h008, 5'd12, "R3 zero shifts");
    pair(ity(12'd40, 5'd13, 3'b001, 5'd12, 7'h13), ity(12'h410, 5'd12, 3'b101, 5'd12, 7'h13), 9'h000, 5'd0, "R3 srai");
    // R4
    pair(ity(12'd16, 5'd2, 3'b000, 5'd14, 7'h13), ldi(3'b011, 5'd14, 5'd14, 12'd8), 9'h010, 5'd14, "R4 addi+ld");
    pair(ity(12'hfff, 5'd2, 3'b000, 5'd14, 7'h13), ldi(3'b010, 5'd14, 5'd14, 12'h800), 9'h020, 5'd14, "R4 addi+lw");
    // R5
    pair(rty(7'h04, 5'd3, 5'd4, 3'b000, 5'd15, 7'h3b), ldi(3'b010, 5'd15, 5'd15, 12'd12), 9'h040, 5'd15, "R5 adduw+lw");
    pair(rty(7'h04, 5'd3, 5'd4, 3'b000, 5'd15, 7'h3b), ldi(3'b011, 5'd15, 5'd15, 12'd12), 9'h000, 5'd0, "R5 adduw+ld");
    // R6
    for (int s = 1; s <= 3; s++)
      for (int l = 0; l <= 3; l++)
        pair(rty(7'h10, 5'd9, 5'd8, 3'(2*s), 5'd20, 7'h33), ldi(3'(l), 5'd20, 5'd20, 12'd4), 9'h080, 5'd20, "R6 shadd+load");
    for (int s = 1; s <= 3; s++)
      pair(rty(7'h10, 5'd9, 5'd8, 3'(2*s), 5'd21, 7'h3b), ldi(3'(s), 5'd21, 5'd21, 12'd0), 9'h100, 5'd21, "R6 shadduw+load");
    for (int l = 4; l <= 6; l++)
      pair(rty(7'h10, 5'd9, 5'd8, 3'b110, 5'd20, 7'h33), ldi(3'(l), 5'd20, 5'd20, 12'd0), 9'h000, 5'd0, "R6 unsigned load");
    // R7
    pair(add5, ldi(3'b010, 5'd6, 5'd5, 12'd0), 9'h000, 5'd0, "R7 rd mismatch");
    pair(add5, ldi(3'b010, 5'd5, 5'd6, 12'd0), 9'h000, 5'd0, "R7 rs1 mismatch");
    pair(ity(12'd40, 5'd13, 3'b001, 5'd12, 7'h13), ity(12'd3, 5'd13, 3'b101, 5'd12, 7'h13), 9'h000, 5'd0, "R7 srli source");
    pair(lw5, add5, 9'h000, 5'd0, "R7 swapped order");
    // R8
    pair(rty(7'h00, 5'd7, 5'd6, 3'b000, 5'd0, 7'h33), ldi(3'b010, 5'd0, 5'd0, 12'd0), 9'h000, 5'd0, "R8 x0");
    // R9
    drive(1'b0, 1'b0, add5, 1'b1, lw5, 9'h1ff, 9'd0, 5'd0, "R9 old invalid");
    drive(1'b0, 1'b1, add5, 1'b0, lw5, 9'h1ff, 9'd0, 5'd0, "R9 young invalid");
    // R10
    drive(1'b0, 1'b1, add5, 1'b1, lw5, 9'h1fe, 9'd0, 5'd0, "R10 kind0 disabled");
    drive(1'b0, 1'b1, uty(20'h1, 5'd10, 7'h17), 1'b1, ldi(3'b011, 5'd10, 5'd10, 12'd0), 9'h1fe, 9'h002, 5'd10, "R10 other kind enabled");
    drive(1'b0, 1'b1, uty(20'h1, 5'd10, 7'h17), 1'b1, ldi(3'b011, 5'd10, 5'd10, 12'd0), 9'h000, 9'h000, 5'd0, "R10 all disabled");
    // R11/R12: back-to-back alternation
    pair(add5, lw5, 9'h001, 5'd5, "R11 alt fuse");
    pair(add5, ldi(3'b010, 5'd5, 5'd5, 12'd1), 9'h000, 5'd0, "R11 alt idle");
    pair(add5, lw5, 9'h001, 5'd5, "R12 alt fuse");
    // R12: reset reasserted mid-run
    drive(1'b1, 1'b1, add5, 1'b1, lw5, 9'h1ff, 9'd0, 5'd0, "R12 reassert");
    pair(add5, lw5, 9'h001, 5'd5, "R12 after reset");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule